// File: doc/BRIEF.md
# Mode-Controlled Direct-Mapped Data Cache

This block is a direct-mapped data cache with a fill and write policy chosen by two mode bits: `CD` (cache disable) and `NW` (no write-through). CPU word reads and writes are looked up in a tag/state array and a data array. Lines are moved over a word-wide memory port that uses a request/acknowledge handshake. The port carries line fills, single-word write-throughs, uncached accesses and dirty-line write-backs.

Each line holds one of four states: invalid, shared, exclusive or modified.

- **Normal mode (CD=0, NW=0):** misses allocate.
- **No-fill mode (CD=1):** lines already in the cache keep serving hits, but no miss ever allocates. The controller starts in this mode after reset.
- **Illegal mode (CD=0, NW=1):** writing this combination is refused. The refusal raises a protection fault with error code zero.

Line invalidation requests and external snoop probes are honoured in every mode. A snoop that finds a modified line writes it back first.

Requests are single-cycle pulses. They are accepted only in a cycle where `cpu_busy` is low. When several arrive in the same cycle, a snoop takes precedence over an invalidation, and an invalidation takes precedence over a CPU access.

Top module: `mcache_ctrl`

## Requirements
- R1: After reset the mode reads CD=1 and NW=0, `gp_fault` is low, `cpu_busy` is low and `mem_req` is low.
- R2: A mode write with CD=0 and NW=1 leaves both mode bits unchanged. One cycle later it pulses `gp_fault` while `gp_code` reads 0. Any other combination is applied in the cycle after the write and raises no fault.
- R3: In normal mode:
  - A read hit pulses `cpu_done` with the cached word one cycle after the request, with no memory traffic.
  - A read miss reads the whole line (LINE_WORDS memory reads, offsets 0 upward) and then returns the requested word.
- R4: In normal mode a write miss first fills the line with LINE_WORDS reads, then merges the written word into the cache. It makes no memory write.
- R5: A write hit to an exclusive or modified line updates only the cache and leaves the line modified. A write hit to a shared line also performs one memory write of that word and then leaves the line exclusive, so a following write hit makes no memory traffic.
- R6: A filled line becomes shared when `mem_shared` is high on the last fill acknowledge. Otherwise it becomes exclusive.
- R7: A normal-mode miss whose target line is modified first writes the old line back (LINE_WORDS memory writes to the old address), then fills the new line.
- R8: With CD=1 a read miss performs one memory read of that word, returns it and allocates nothing, so repeating it misses again.
- R9: With CD=1:
  - A write miss performs one memory write and allocates nothing.
  - Read and write hits are still served from, and update, the cache without memory traffic.
- R10: A snoop on a modified line writes the line back, then reports `snp_hit`=1 and `snp_hitm`=1 and invalidates the line. A snoop on a clean line invalidates it with no traffic and reports `snp_hit`=1, `snp_hitm`=0. A snoop miss reports `snp_hit`=0.
- R11: An invalidation request on a matching line drops it without write-back in either mode, so the next access to it misses.
- R12: `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`, and `cpu_busy` is high whenever `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Write the mode bits this cycle |
| mode_cd_in | input | 1 | New cache-disable bit |
| mode_nw_in | input | 1 | New no-write-through bit |
| mode_cd | output | 1 | Current cache-disable bit |
| mode_nw | output | 1 | Current no-write-through bit |
| gp_fault | output | 1 | One-cycle protection-fault pulse on an illegal mode write |
| gp_code | output | CODE_W | Fault error code (always 0) |
| cpu_req | input | 1 | CPU access pulse |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_busy | output | 1 | Controller is busy; requests are not accepted |
| cpu_done | output | 1 | CPU access completed |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| inv_req | input | 1 | Line invalidation pulse |
| inv_addr | input | ADDR_W | Address to invalidate |
| snp_req | input | 1 | Snoop probe pulse |
| snp_addr | input | ADDR_W | Snoop address |
| snp_done | output | 1 | Snoop completed |
| snp_hit | output | 1 | Snoop found the line |
| snp_hitm | output | 1 | Snoop found the line modified |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepted or completed the word |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_shared | input | 1 | Filled line is held elsewhere |

## Verification
The bench counts memory reads and writes across every access, so the traffic around each corner case is checked, not just the data:

- **No-fill read miss:** it must miss again when repeated. A controller that allocated anyway would serve the repeat from the cache with no read.
- **Write hit on a shared line:** exactly one write-through must follow, then none. A design that skipped the exclusive upgrade would write through every time; one that skipped the write-through would leave memory stale.
- **Eviction of a modified line and snoop on a modified line:** both must put the dirty words in memory before the line is reused. A wrong design loses the data, which then shows up as wrong read data after the refill.
- **Illegal mode write:** it must fault without touching the mode. A design that accepted it would report the wrong mode bits.

// File: rtl/mcache_pkg.sv
package mcache_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2,
      LS_MOD = 2'd3
   } line_st_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_EVICT,
      FS_FILL,
      FS_FINISH,
      FS_THRU,
      FS_DIRECT,
      FS_FLUSH
   } fsm_e;

endpackage

// File: rtl/mcache_mode_reg.sv
module mcache_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   input  logic set_cd,
   input  logic set_nw,
   output logic cd,
   output logic nw,
   output logic fault
);

   logic illegal;
   assign illegal = set_en && !set_cd && set_nw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cd    <= 1'b1;
         nw    <= 1'b0;
         fault <= 1'b0;
      end else begin
         fault <= illegal;
         if (set_en && !illegal) begin
            cd <= set_cd;
            nw <= set_nw;
         end
      end
   end

   // R2: refused combination keeps the mode and faults
   a_r2_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !set_cd && set_nw) |=> (fault && $stable(cd) && $stable(nw)));

   // R2: accepted combination lands without a fault
   a_r2_legal_applied: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !(!set_cd && set_nw)) |=> (!fault && cd == $past(set_cd) && nw == $past(set_nw)));

endmodule

// File: rtl/mcache_tag_store.sv
module mcache_tag_store
   import mcache_pkg::*;
#(
   parameter int LINES = 8,
   parameter int TAG_W = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output line_st_e         rd_st,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  line_st_e         wr_st
);

   logic [TAG_W-1:0] tag_vec [LINES];
   line_st_e         st_vec  [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      line_st_e         st_r;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n)   st_r <= LS_INV;
         else if (sel) st_r <= wr_st;
      end

      always_ff @(posedge clk) begin
         if (sel) tag_r <= wr_tag;
      end

      assign tag_vec[g] = tag_r;
      assign st_vec[g]  = st_r;
   end

   assign rd_tag = tag_vec[rd_idx];
   assign rd_st  = st_vec[rd_idx];

endmodule

// File: rtl/mcache_data_store.sv
module mcache_data_store #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl
   import mcache_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int LINES      = 8,
   parameter int CODE_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_set,
   input  logic              mode_cd_in,
   input  logic              mode_nw_in,
   output logic              mode_cd,
   output logic              mode_nw,
   output logic              gp_fault,
   output logic [CODE_W-1:0] gp_code,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              inv_req,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic              snp_req,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_done,
   output logic              snp_hit,
   output logic              snp_hitm,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_shared
);

   localparam int OFF_W = $clog2(LINE_WORDS);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
   localparam int DEPTH = LINES * LINE_WORDS;
   localparam int DA_W  = IDX_W + OFF_W;

   initial begin
      if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS)
         $fatal(1, "LINE_WORDS must be a power of two, at least 2");
      if (LINES < 2 || (1 << IDX_W) != LINES)
         $fatal(1, "LINES must be a power of two, at least 2");
      if (TAG_W < 1)
         $fatal(1, "ADDR_W too narrow for the chosen geometry");
   end

   // ---------------- mode register ----------------
   mcache_mode_reg u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (mode_set),
      .set_cd (mode_cd_in),
      .set_nw (mode_nw_in),
      .cd     (mode_cd),
      .nw     (mode_nw),
      .fault  (gp_fault)
   );
   assign gp_code = '0;

   // ---------------- control state ----------------
   fsm_e              fs_q;
   logic [ADDR_W-1:0] cur_addr_q;
   logic              cur_we_q;
   logic [DATA_W-1:0] cur_wd_q;
   logic [OFF_W-1:0]  cnt_q;
   logic [TAG_W-1:0]  vtag_q;
   logic              wt_hit_q;

   logic idle, take_snp, take_inv, take_cpu, last, hit;
   assign idle     = (fs_q == FS_IDLE);
   assign take_snp = idle && snp_req;
   assign take_inv = idle && !snp_req && inv_req;
   assign take_cpu = idle && !snp_req && !inv_req && cpu_req;
   assign last     = (cnt_q == OFF_W'(LINE_WORDS - 1));

   // ---------------- lookup address ----------------
   logic [ADDR_W-1:0] lk_addr;
   always_comb begin
      if (!idle)        lk_addr = cur_addr_q;
      else if (snp_req) lk_addr = snp_addr;
      else if (inv_req) lk_addr = inv_addr;
      else              lk_addr = cpu_addr;
   end

   logic [OFF_W-1:0] lk_off;
   logic [IDX_W-1:0] lk_idx;
   logic [TAG_W-1:0] lk_tag;
   assign lk_off = lk_addr[OFF_W-1:0];
   assign lk_idx = lk_addr[OFF_W +: IDX_W];
   assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];

   // ---------------- tag / state array ----------------
   logic [TAG_W-1:0] t_tag;
   line_st_e         t_st;
   logic             t_we;
   line_st_e         t_wst;

   mcache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lk_idx),
      .rd_tag (t_tag),
      .rd_st  (t_st),
      .wr_en  (t_we),
      .wr_idx (lk_idx),
      .wr_tag (lk_tag),
      .wr_st  (t_wst)
   );

   assign hit = (t_st != LS_INV) && (t_tag == lk_tag);

   always_comb begin
      t_we  = 1'b0;
      t_wst = LS_INV;
      case (fs_q)
         FS_IDLE: begin
            if (take_snp && hit && t_st != LS_MOD) begin
               t_we = 1'b1; t_wst = LS_INV;
            end else if (take_inv && hit) begin
               t_we = 1'b1; t_wst = LS_INV;
            end else if (take_cpu && cpu_we && hit && t_st != LS_SHR) begin
               t_we = 1'b1; t_wst = LS_MOD;
            end
         end
         FS_FILL: if (mem_ack && last) begin
            t_we = 1'b1; t_wst = mem_shared ? LS_SHR : LS_EXC;
         end
         FS_FINISH: if (cur_we_q && t_st != LS_SHR) begin
            t_we = 1'b1; t_wst = LS_MOD;
         end
         FS_THRU: if (mem_ack && wt_hit_q) begin
            t_we = 1'b1; t_wst = LS_EXC;
         end
         FS_FLUSH: if (mem_ack && last) begin
            t_we = 1'b1; t_wst = LS_INV;
         end
         default: ;
      endcase
   end

   // ---------------- data array ----------------
   logic [DA_W-1:0]   d_ra, d_wa;
   logic [DATA_W-1:0] d_rd, d_wd;
   logic              d_we;

   mcache_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rd_addr (d_ra),
      .rd_data (d_rd),
      .wr_en   (d_we),
      .wr_addr (d_wa),
      .wr_data (d_wd)
   );

   always_comb begin
      if (fs_q == FS_EVICT || fs_q == FS_FLUSH) d_ra = {lk_idx, cnt_q};
      else                                      d_ra = {lk_idx, lk_off};
   end

   always_comb begin
      d_we = 1'b0;
      d_wa = {lk_idx, lk_off};
      d_wd = cur_wd_q;
      if (take_cpu && cpu_we && hit) begin
         d_we = 1'b1;
         d_wd = cpu_wdata;
      end else if (fs_q == FS_FILL && mem_ack) begin
         d_we = 1'b1;
         d_wa = {lk_idx, cnt_q};
         d_wd = mem_rdata;
      end else if (fs_q == FS_FINISH && cur_we_q) begin
         d_we = 1'b1;
      end
   end

   // ---------------- memory port ----------------
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_addr_q;
      mem_wdata = d_rd;
      case (fs_q)
         FS_EVICT: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = {vtag_q, lk_idx, cnt_q};
         end
         FS_FLUSH: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = {lk_tag, lk_idx, cnt_q};
         end
         FS_FILL: begin
            mem_req = 1'b1; mem_addr = {lk_tag, lk_idx, cnt_q};
         end
         FS_THRU: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_wdata = cur_wd_q;
         end
         FS_DIRECT: mem_req = 1'b1;
         default: ;
      endcase
   end

   assign cpu_busy = !idle;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q       <= FS_IDLE;
         cur_addr_q <= '0;
         cur_we_q   <= 1'b0;
         cur_wd_q   <= '0;
         cnt_q      <= '0;
         vtag_q     <= '0;
         wt_hit_q   <= 1'b0;
         cpu_done   <= 1'b0;
         cpu_rdata  <= '0;
         snp_done   <= 1'b0;
         snp_hit    <= 1'b0;
         snp_hitm   <= 1'b0;
      end else begin
         cpu_done <= 1'b0;
         snp_done <= 1'b0;
         case (fs_q)
            FS_IDLE: begin
               if (take_snp) begin
                  cur_addr_q <= snp_addr;
                  if (hit && t_st == LS_MOD) begin
                     cnt_q <= '0;
                     fs_q  <= FS_FLUSH;
                  end else begin
                     snp_done <= 1'b1;
                     snp_hit  <= hit;
                     snp_hitm <= 1'b0;
                  end
               end else if (take_cpu) begin
                  cur_addr_q <= cpu_addr;
                  cur_we_q   <= cpu_we;
                  cur_wd_q   <= cpu_wdata;
                  if (hit) begin
                     if (cpu_we && t_st == LS_SHR) begin
                        wt_hit_q <= 1'b1;
                        fs_q     <= FS_THRU;
                     end else begin
                        cpu_done  <= 1'b1;
                        cpu_rdata <= d_rd;
                     end
                  end else if (mode_cd) begin
                     wt_hit_q <= 1'b0;
                     fs_q     <= cpu_we ? FS_THRU : FS_DIRECT;
                  end else begin
                     vtag_q <= t_tag;
                     cnt_q  <= '0;
                     fs_q   <= (t_st == LS_MOD) ? FS_EVICT : FS_FILL;
                  end
               end
            end
            FS_EVICT: if (mem_ack) begin
               cnt_q <= cnt_q + OFF_W'(1);
               if (last) fs_q <= FS_FILL;
            end
            FS_FILL: if (mem_ack) begin
               cnt_q <= cnt_q + OFF_W'(1);
               if (last) fs_q <= FS_FINISH;
            end
            FS_FINISH: begin
               if (cur_we_q && t_st == LS_SHR) begin
                  wt_hit_q <= 1'b1;
                  fs_q     <= FS_THRU;
               end else begin
                  cpu_done  <= 1'b1;
                  cpu_rdata <= d_rd;
                  fs_q      <= FS_IDLE;
               end
            end
            FS_THRU: if (mem_ack) begin
               cpu_done <= 1'b1;
               fs_q     <= FS_IDLE;
            end
            FS_DIRECT: if (mem_ack) begin
               cpu_done  <= 1'b1;
               cpu_rdata <= mem_rdata;
               fs_q      <= FS_IDLE;
            end
            FS_FLUSH: if (mem_ack) begin
               cnt_q <= cnt_q + OFF_W'(1);
               if (last) begin
                  snp_done <= 1'b1;
                  snp_hit  <= 1'b1;
                  snp_hitm <= 1'b1;
                  fs_q     <= FS_IDLE;
               end
            end
            default: fs_q <= FS_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   // R12: request held steady until acknowledged
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R12: busy covers every memory transaction
   a_r12_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_busy);

   // R8/R9: a miss with caching disabled never starts a fill
   a_r8_nofill_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (take_cpu && !hit && mode_cd) |=> (fs_q == FS_DIRECT || fs_q == FS_THRU));

   // R5: write hit on a shared line goes through to memory
   a_r5_shared_thru: assert property (@(posedge clk) disable iff (!rst_n)
      (take_cpu && cpu_we && hit && t_st == LS_SHR) |=> (fs_q == FS_THRU));

   // R7: write-back of a dirty victim is followed by the fill
   a_r7_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_q == FS_EVICT && mem_ack && last) |=> (fs_q == FS_FILL));

   // R10: a modified hit is always also a hit
   a_r10_hitm_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_done && snp_hitm) |-> snp_hit);

endmodule

// File: tb/tb_mcache_ctrl.sv
`timescale 1ns/1ps
module tb_mcache_ctrl;

   localparam int AW = 8;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic mode_set = 0, mode_cd_in = 0, mode_nw_in = 0;
   logic mode_cd, mode_nw, gp_fault;
   logic [7:0] gp_code;
   logic cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_busy, cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic inv_req = 0;
   logic [AW-1:0] inv_addr = '0;
   logic snp_req = 0;
   logic [AW-1:0] snp_addr = '0;
   logic snp_done, snp_hit, snp_hitm;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic mem_ack;
   logic [DW-1:0] mem_rdata;
   logic mem_shared = 0;

   mcache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(4), .LINES(8)) dut (
      .clk(clk), .rst_n(rst_n),
      .mode_set(mode_set), .mode_cd_in(mode_cd_in), .mode_nw_in(mode_nw_in),
      .mode_cd(mode_cd), .mode_nw(mode_nw), .gp_fault(gp_fault), .gp_code(gp_code),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .inv_req(inv_req), .inv_addr(inv_addr),
      .snp_req(snp_req), .snp_addr(snp_addr),
      .snp_done(snp_done), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_shared(mem_shared)
   );

   // ---------------- memory model ----------------
   logic [DW-1:0] bmem [256];
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
         for (int i = 0; i < 256; i++) bmem[i] <= 32'hD000_0000 | i;
      end else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) bmem[mem_addr] <= mem_wdata;
         mem_rdata <= bmem[mem_addr];
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // ---------------- bookkeeping ----------------
   int n_chk = 0, n_err = 0;
   int rd_n = 0, wr_n = 0, hs_bad = 0;
   bit done_all = 0;
   logic [DW-1:0] refm [256];

   task automatic chk(input bit ok, input string r, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
      end
   endtask

   // ---------------- scoreboard ----------------
   bit            q_rd [$];
   logic [DW-1:0] q_v  [$];
   string         q_r  [$];

   logic          p_req, p_ack, p_we;
   logic [AW-1:0] p_addr;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_req = 0; p_ack = 0; p_we = 0; p_addr = '0;
      end else begin
         if (mem_req && mem_ack) begin
            if (mem_we) wr_n++; else rd_n++;
         end
         if (p_req && !p_ack && !(mem_req && mem_addr == p_addr && mem_we == p_we)) hs_bad++;
         if (mem_req && !cpu_busy) hs_bad++;
         p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_addr = mem_addr;
         if (cpu_done) begin
            if (q_rd.size() == 0) begin
               chk(0, "R3", "unexpected cpu_done", 1, 0);
            end else begin
               bit rd = q_rd.pop_front();
               logic [DW-1:0] v = q_v.pop_front();
               string r = q_r.pop_front();
               if (rd) chk(cpu_rdata === v, r, "read data", cpu_rdata, v);
            end
         end
      end
   end

   // ---------------- driver tasks ----------------
   task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input int exp_rd, input int exp_wr, input string r);
      int r0, w0;
      @(negedge clk);
      while (cpu_busy) @(negedge clk);
      r0 = rd_n; w0 = wr_n;
      q_rd.push_back(!we); q_v.push_back(refm[a]); q_r.push_back(r);
      if (we) refm[a] = wd;
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 0;
      while (!cpu_done) @(negedge clk);
      chk(rd_n - r0 == exp_rd, r, "memory reads", rd_n - r0, exp_rd);
      chk(wr_n - w0 == exp_wr, r, "memory writes", wr_n - w0, exp_wr);
   endtask

   task automatic snoop(input logic [AW-1:0] a, input bit eh, input bit ehm,
                        input int exp_wr, input string r);
      int w0;
      @(negedge clk);
      while (cpu_busy) @(negedge clk);
      w0 = wr_n;
      snp_req = 1; snp_addr = a;
      @(negedge clk);
      snp_req = 0;
      while (!snp_done) @(negedge clk);
      chk(snp_hit == eh, r, "snp_hit", snp_hit, eh);
      chk(snp_hitm == ehm, r, "snp_hitm", snp_hitm, ehm);
      chk(wr_n - w0 == exp_wr, r, "snoop write-back words", wr_n - w0, exp_wr);
   endtask

   task automatic inval(input logic [AW-1:0] a);
      @(negedge clk);
      while (cpu_busy) @(negedge clk);
      inv_req = 1; inv_addr = a;
      @(negedge clk);
      inv_req = 0;
   endtask

   task automatic set_mode(input bit cd, input bit nw, input bit exp_fault,
                           input bit ecd, input bit enw);
      @(negedge clk);
      mode_set = 1; mode_cd_in = cd; mode_nw_in = nw;
      @(negedge clk);
      mode_set = 0;
      chk(gp_fault == exp_fault, "R2", "gp_fault", gp_fault, exp_fault);
      chk(gp_code == 0, "R2", "gp_code", gp_code, 0);
      chk(mode_cd == ecd && mode_nw == enw, "R2", "mode bits",
          {mode_cd, mode_nw}, {ecd, enw});
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done_all) begin
         done_all = 1;
         n_chk++; n_err++;
         $display("FAIL R12 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 256; i++) refm[i] = 32'hD000_0000 | i;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(mode_cd == 1 && mode_nw == 0, "R1", "reset mode", {mode_cd, mode_nw}, 2'b10);
      chk(!gp_fault && !cpu_busy && !mem_req, "R1", "reset idle",
          {gp_fault, cpu_busy, mem_req}, 0);

      // R2 illegal write refused
      set_mode(0, 1, 1, 1, 0);

      // R8 no-fill read miss, no allocation
      cpu_op(0, 8'h10, 0, 1, 0, "R8");
      cpu_op(0, 8'h10, 0, 1, 0, "R8");
      // R9 no-fill write miss
      cpu_op(1, 8'h11, 32'h1111_AAAA, 0, 1, "R9");
      chk(bmem[8'h11] == 32'h1111_AAAA, "R9", "memory word", bmem[8'h11], 32'h1111_AAAA);

      // R2 legal write: normal mode
      set_mode(0, 0, 0, 0, 0);

      // R3 read miss fills, then hit
      cpu_op(0, 8'h12, 0, 4, 0, "R3");
      cpu_op(0, 8'h11, 0, 0, 0, "R3");
      // R5 write hit on exclusive line
      cpu_op(1, 8'h13, 32'h2222_BBBB, 0, 0, "R5");
      cpu_op(0, 8'h13, 0, 0, 0, "R5");
      // R7 conflicting miss evicts modified line
      cpu_op(0, 8'h30, 0, 4, 4, "R7");
      chk(bmem[8'h13] == 32'h2222_BBBB, "R7", "written back word", bmem[8'h13], 32'h2222_BBBB);

      // R6 shared fill, R5 write-through then upgrade
      mem_shared = 1;
      cpu_op(0, 8'h50, 0, 4, 0, "R6");
      mem_shared = 0;
      cpu_op(1, 8'h51, 32'h3333_CCCC, 0, 1, "R5");
      chk(bmem[8'h51] == 32'h3333_CCCC, "R5", "write-through word", bmem[8'h51], 32'h3333_CCCC);
      cpu_op(1, 8'h52, 32'h4444_DDDD, 0, 0, "R5");

      // R10 snoop on modified line
      snoop(8'h50, 1, 1, 4, "R10");
      chk(bmem[8'h52] == 32'h4444_DDDD, "R10", "snoop write-back", bmem[8'h52], 32'h4444_DDDD);
      cpu_op(0, 8'h52, 0, 4, 0, "R10");
      // R10 clean hit, then miss
      snoop(8'h53, 1, 0, 0, "R10");
      cpu_op(0, 8'h50, 0, 4, 0, "R10");
      snoop(8'h70, 0, 0, 0, "R10");

      // R4 write miss allocates without memory write
      cpu_op(1, 8'h84, 32'h5555_EEEE, 4, 0, "R4");
      chk(bmem[8'h84] == 32'hD000_0084, "R4", "memory untouched", bmem[8'h84], 32'hD000_0084);
      cpu_op(0, 8'h84, 0, 0, 0, "R4");

      // R11 invalidate in normal mode
      inval(8'h50);
      cpu_op(0, 8'h51, 0, 4, 0, "R11");
      // R11 invalidate in no-fill mode
      set_mode(1, 0, 0, 1, 0);
      inval(8'h51);
      cpu_op(0, 8'h50, 0, 1, 0, "R11");
      cpu_op(0, 8'h50, 0, 1, 0, "R8");
      // R9 hits still served in no-fill mode
      cpu_op(1, 8'h85, 32'h6666_FFFF, 0, 0, "R9");
      cpu_op(0, 8'h85, 0, 0, 0, "R9");
      cpu_op(0, 8'h84, 0, 0, 0, "R9");

      // R12 handshake and busy observed throughout
      chk(hs_bad == 0, "R12", "handshake violations", hs_bad, 0);

      repeat (4) @(negedge clk);
      if (!done_all) begin
         done_all = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule